// File: doc/BRIEF.md
# CPU Clock and Standby Controller

This block makes the CPU cycle timing for a small microcontroller. It has two oscillators to choose from: a fast main oscillator and a slow sub oscillator. Each oscillator arrives as a one-cycle tick in a single synchronous domain. Every output is also a one-cycle clock-enable pulse. The CPU cycle enable divides the selected source. On the main oscillator the divide is one of four ratios. On the sub oscillator the ratio is fixed. A peripheral enable is divided from the main oscillator alone. A watch-timer enable follows the sub oscillator in every mode.

Software sets the block up through a small write port. That port reaches two registers: a 2-bit speed selector and a 4-bit source/oscillator register. The core can ask for a halt, where the CPU pauses and the oscillators keep running. It can also ask for a deep stop, where the main oscillator is shut down. A wake event ends either mode. Leaving a deep stop waits a programmable number of main ticks before the CPU runs again, so the oscillator can settle.

The block has no data stream. All pins are plain control or status lines, so there is no valid/ready handshake.

Top module: `cpu_clkgen_ctl`

## Requirements
- R1: After reset the speed selector and the source register are both 0. The CPU runs from the main oscillator with a cycle of 64 main ticks, and `main_osc_on` is 1.
- R2: On the main oscillator, the speed selector (write address 0, data bits [1:0]) sets the CPU cycle: 0 gives 64 main ticks, 1 gives 16, 2 gives 8 and 3 gives 4. Exactly one `cpu_ce` pulse is issued per cycle.
- R3: Writing the source register (address 1) with bit 0 set selects the sub oscillator. The CPU cycle is then 4 sub ticks, and `cpu_src_sub` reads 1.
- R4: A new speed or source setting takes effect only at the next CPU cycle boundary. The cycle in progress when the write lands keeps its old length.
- R5: Source register bit 3 stops the main oscillator. It is accepted only if the sub oscillator is already the active CPU source and bit 0 is set in the same write. Otherwise the stop bit reads as 0. `main_osc_on` shows the result.
- R6: A one-cycle `stop_req` on the main oscillator enters deep stop. While stopped, `main_osc_on` is 0 and neither `cpu_ce` nor `periph_ce` pulses.
- R7: A `stop_req` while the sub oscillator is the active source is ignored. CPU pulses continue and `main_osc_on` does not change.
- R8: A `halt_req` halts the CPU. No `cpu_ce` is issued until `wake_irq`, and the CPU runs again from the next cycle. A halt works on either source.
- R9: A `wake_irq` in deep stop turns the main oscillator back on at the next cycle. `cpu_ce` stays off for `settle_len` further main ticks (one cycle if `settle_len` is 0), and then resumes.
- R10: `watch_ce` equals `sub_tick` in every mode, including deep stop.
- R11: `periph_ce` pulses once every 2 main ticks while the main oscillator runs, including during a halt. It gives no pulse while the oscillator is stopped by bit 3, in deep stop, or while settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_tick | input | 1 | One pulse per main oscillator period |
| sub_tick | input | 1 | One pulse per sub oscillator period |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = speed selector, 1 = source register |
| cfg_wdata | input | 4 | Write data |
| settle_len | input | 8 | Main ticks to wait when leaving deep stop |
| halt_req | input | 1 | Halt request pulse |
| stop_req | input | 1 | Deep-stop request pulse |
| wake_irq | input | 1 | Wake event |
| cpu_ce | output | 1 | CPU cycle enable pulse |
| periph_ce | output | 1 | Peripheral enable pulse |
| watch_ce | output | 1 | Watch-timer enable pulse |
| main_osc_on | output | 1 | Main oscillator enable |
| cpu_src_sub | output | 1 | Active CPU source is the sub oscillator |

## Verification
The bench writes speed and source changes at the start of a cycle. It then checks that the cycle already running keeps its old length. A design that applies a write at once would shorten or stretch that cycle. It tries to stop the main oscillator from the main source, and tries a deep stop from the sub source. A design that allows either would cut off the CPU clock for good. It times the settle window after a wake from deep stop, and keeps counting watch-timer pulses through every mode. A design that resumed early, or gated the watch path, would lose CPU cycles there or miss timekeeping pulses.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_STOP   = 2'd2,
    ST_SETTLE = 2'd3
  } stby_e;

  localparam int SPD_W   = 2;
  localparam int SRC_W   = 4;
  localparam int SRC_BIT = 0;
  localparam int OFF_BIT = 3;
endpackage

// File: rtl/ckg_regs.sv
module ckg_regs
  import ckg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             addr,
  input  logic [SRC_W-1:0] wdata,
  input  logic             act_sub,
  output logic [SPD_W-1:0] spd_q,
  output logic             src_sub_q,
  output logic             osc_off_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spd_q     <= '0;
      src_sub_q <= 1'b0;
      osc_off_q <= 1'b0;
    end else if (we) begin
      if (!addr) begin
        spd_q <= wdata[SPD_W-1:0];
      end else begin
        src_sub_q <= wdata[SRC_BIT];
        // stop of the main oscillator only while the sub source already drives the CPU
        osc_off_q <= wdata[OFF_BIT] & wdata[SRC_BIT] & act_sub;
      end
    end
  end
endmodule

// File: rtl/ckg_cycle_div.sv
module ckg_cycle_div
  import ckg_pkg::*;
#(
  parameter int DIV0    = 64,
  parameter int DIV1    = 16,
  parameter int DIV2    = 8,
  parameter int DIV3    = 4,
  parameter int SUB_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_ok,
  input  logic             sub_tick,
  input  logic             req_sub,
  input  logic [SPD_W-1:0] req_spd,
  input  logic             run_ok,
  output logic             cpu_ce,
  output logic             cycle_end,
  output logic             act_sub,
  output logic [SPD_W-1:0] act_spd
);
  localparam int CNT_W = $clog2(DIV0);
  localparam logic [CNT_W-1:0] L0 = CNT_W'(DIV0 - 1);
  localparam logic [CNT_W-1:0] L1 = CNT_W'(DIV1 - 1);
  localparam logic [CNT_W-1:0] L2 = CNT_W'(DIV2 - 1);
  localparam logic [CNT_W-1:0] L3 = CNT_W'(DIV3 - 1);
  localparam logic [CNT_W-1:0] LS = CNT_W'(SUB_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             src_tick;

  always_comb begin
    if (act_sub) begin
      last = LS;
    end else begin
      case (act_spd)
        2'd0:    last = L0;
        2'd1:    last = L1;
        2'd2:    last = L2;
        default: last = L3;
      endcase
    end
  end

  assign src_tick  = act_sub ? sub_tick : main_ok;
  assign cycle_end = src_tick && (cnt_q == last);
  assign cpu_ce    = cycle_end && run_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_sub <= 1'b0;
      act_spd <= '0;
    end else if (src_tick) begin
      if (cycle_end) begin
        cnt_q   <= '0;
        act_sub <= req_sub;
        act_spd <= req_spd;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ckg_periph_div.sv
module ckg_periph_div #(
  parameter int PDIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok,
  output logic periph_ce
);
  generate
    if (PDIV <= 1) begin : g_pass
      assign periph_ce = main_ok;
    end else begin : g_div
      localparam int PW = $clog2(PDIV);
      localparam logic [PW-1:0] PLAST = PW'(PDIV - 1);
      logic [PW-1:0] pcnt_q;
      assign periph_ce = main_ok && (pcnt_q == PLAST);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pcnt_q <= '0;
        end else if (main_ok) begin
          pcnt_q <= (pcnt_q == PLAST) ? '0 : pcnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ckg_standby.sv
module ckg_standby
  import ckg_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                stop_req,
  input  logic                wake_irq,
  input  logic                act_sub,
  input  logic                main_tick,
  input  logic [SETTLE_W-1:0] settle_len,
  output stby_e               st_q
);
  logic [SETTLE_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      wait_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (stop_req && !act_sub) st_q <= ST_STOP;
          else if (halt_req)        st_q <= ST_HALT;
        end
        ST_HALT: begin
          if (wake_irq) st_q <= ST_RUN;
        end
        ST_STOP: begin
          if (wake_irq) begin
            st_q   <= ST_SETTLE;
            wait_q <= settle_len;
          end
        end
        ST_SETTLE: begin
          if (wait_q == '0) begin
            st_q <= ST_RUN;
          end else if (main_tick) begin
            if (wait_q == SETTLE_W'(1)) st_q <= ST_RUN;
            wait_q <= wait_q - 1'b1;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/cpu_clkgen_ctl.sv
module cpu_clkgen_ctl
  import ckg_pkg::*;
#(
  parameter int DIV0     = 64,
  parameter int DIV1     = 16,
  parameter int DIV2     = 8,
  parameter int DIV3     = 4,
  parameter int SUB_DIV  = 4,
  parameter int PDIV     = 2,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                main_tick,
  input  logic                sub_tick,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [3:0]          cfg_wdata,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                halt_req,
  input  logic                stop_req,
  input  logic                wake_irq,
  output logic                cpu_ce,
  output logic                periph_ce,
  output logic                watch_ce,
  output logic                main_osc_on,
  output logic                cpu_src_sub
);
  logic [SPD_W-1:0] req_spd;
  logic [SPD_W-1:0] act_spd;
  logic             req_sub;
  logic             act_sub;
  logic             osc_off;
  logic             main_ok;
  logic             cycle_end;
  stby_e            st_q;

  ckg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .act_sub(act_sub),
    .spd_q(req_spd), .src_sub_q(req_sub), .osc_off_q(osc_off)
  );

  ckg_standby #(.SETTLE_W(SETTLE_W)) u_stby (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .wake_irq(wake_irq), .act_sub(act_sub), .main_tick(main_tick),
    .settle_len(settle_len), .st_q(st_q)
  );

  assign main_osc_on = !osc_off && (st_q != ST_STOP);
  assign main_ok     = main_tick && !osc_off && (st_q == ST_RUN || st_q == ST_HALT);

  ckg_cycle_div #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .SUB_DIV(SUB_DIV)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .sub_tick(sub_tick),
    .req_sub(req_sub), .req_spd(req_spd), .run_ok(st_q == ST_RUN),
    .cpu_ce(cpu_ce), .cycle_end(cycle_end), .act_sub(act_sub), .act_spd(act_spd)
  );

  ckg_periph_div #(.PDIV(PDIV)) u_pdiv (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .periph_ce(periph_ce)
  );

  assign watch_ce    = sub_tick;
  assign cpu_src_sub = act_sub;
endmodule

// File: rtl/ckg_checker.sv
module ckg_checker
  import ckg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input stby_e            st,
  input logic             stop_req,
  input logic             wake_irq,
  input logic             cpu_ce,
  input logic             periph_ce,
  input logic             main_osc_on,
  input logic             osc_off,
  input logic             act_sub,
  input logic [SPD_W-1:0] act_spd,
  input logic             cycle_end
);
  a_r4_cfg_holds_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> ($stable(act_sub) && $stable(act_spd)));

  a_r5_off_needs_sub: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |-> act_sub);

  a_r6_quiet_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP || st == ST_SETTLE) |-> (!cpu_ce && !periph_ce));

  a_r7_no_stop_on_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && stop_req && act_sub) |=> (st != ST_STOP));

  a_r8_halt_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT && wake_irq) |=> (st == ST_RUN));

  a_r8_no_ce_unless_run: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN) |-> !cpu_ce);

  a_r11_periph_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ce |-> main_osc_on);
endmodule

bind cpu_clkgen_ctl ckg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .stop_req(stop_req), .wake_irq(wake_irq),
  .cpu_ce(cpu_ce), .periph_ce(periph_ce), .main_osc_on(main_osc_on),
  .osc_off(osc_off), .act_sub(act_sub), .act_spd(act_spd), .cycle_end(cycle_end)
);

// File: tb/sim_cpu_clkgen_ctl.sv
`timescale 1ns/1ps
module sim_cpu_clkgen_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_tick = 1'b1;
  logic sub_tick = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_addr = 1'b0;
  logic [3:0] cfg_wdata = 4'h0;
  logic [7:0] settle_len = 8'd0;
  logic halt_req = 1'b0;
  logic stop_req = 1'b0;
  logic wake_irq = 1'b0;
  logic cpu_ce, periph_ce, watch_ce, main_osc_on, cpu_src_sub;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_ce = 0;
  int last_per = 0;
  int ce_cnt = 0;
  int per_cnt = 0;
  int watch_cnt = 0;
  int watch_bad = 0;
  int sub_ph = 0;
  logic [1:0] cur_spd = 2'd0;

  always #5 clk = ~clk;

  cpu_clkgen_ctl u0 (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .settle_len(settle_len), .halt_req(halt_req), .stop_req(stop_req),
    .wake_irq(wake_irq), .cpu_ce(cpu_ce), .periph_ce(periph_ce),
    .watch_ce(watch_ce), .main_osc_on(main_osc_on), .cpu_src_sub(cpu_src_sub)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    #2;
    sub_tick = (sub_ph == 0);
    sub_ph = (sub_ph == 2) ? 0 : sub_ph + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (watch_ce !== sub_tick) watch_bad = watch_bad + 1;
      if (watch_ce) watch_cnt = watch_cnt + 1;
      if (periph_ce) per_cnt = per_cnt + 1;
      if (cpu_ce) begin
        last_per = cyc - last_ce;
        last_ce = cyc;
        ce_cnt = ce_cnt + 1;
      end
    end
  end

  function automatic int exp_main(input logic [1:0] s);
    case (s)
      2'd0: return 64;
      2'd1: return 16;
      2'd2: return 8;
      default: return 4;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #2; sig = 1'b1;
    @(posedge clk); #2; sig = 1'b0;
  endtask

  task automatic wait_ces(input int n);
    int t;
    t = ce_cnt + n;
    wait (ce_cnt >= t);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, p0, w0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 main_osc_on", main_osc_on, 1);
    chk("R1 cpu_src_sub", cpu_src_sub, 0);
    wait_ces(2);
    chk("R1 slowest period", last_per, 64);

    // R2/R4 random speed changes applied at the boundary
    for (int i = 0; i < 12; i++) begin
      logic [1:0] nv;
      nv = 2'($urandom_range(0, 3));
      wait_ces(1);
      wr(1'b0, {2'b00, nv});
      wait_ces(1);
      chk("R4 old length kept", last_per, exp_main(cur_spd));
      wait_ces(1);
      chk("R2 new period", last_per, exp_main(nv));
      cur_spd = nv;
    end
    wait_ces(1);
    wr(1'b0, 4'h3);
    wait_ces(2);
    cur_spd = 2'd3;
    chk("R2 fastest period", last_per, 4);

    // R11 periph on main
    idle(2); p0 = per_cnt; idle(100);
    chk("R11 periph rate", (per_cnt - p0 >= 49 && per_cnt - p0 <= 51) ? 1 : 0, 1);

    // R5 stop bit rejected on main source
    wr(1'b1, 4'h8);
    idle(4);
    chk("R5 reject on main", main_osc_on, 1);
    chk("R5 still main", cpu_src_sub, 0);

    // R6 deep stop on main
    settle_len = 8'd20;
    pulse(stop_req);
    idle(3);
    c0 = ce_cnt; p0 = per_cnt; w0 = watch_cnt;
    idle(50);
    chk("R6 osc off in stop", main_osc_on, 0);
    chk("R6 no cpu_ce", ce_cnt - c0, 0);
    chk("R11 no periph in stop", per_cnt - p0, 0);
    chk("R10 watch runs in stop", (watch_cnt - w0 > 10) ? 1 : 0, 1);

    // R9 wake and settle
    @(posedge clk); #2 wake_irq = 1'b1;
    @(posedge clk); #2 wake_irq = 1'b0;
    c0 = ce_cnt;
    @(negedge clk);
    chk("R9 osc on after wake", main_osc_on, 1);
    idle(17);
    chk("R9 quiet while settling", ce_cnt - c0, 0);
    idle(30);
    chk("R9 resumes", (ce_cnt - c0 > 0) ? 1 : 0, 1);

    // R8 halt on main
    pulse(halt_req);
    idle(2);
    c0 = ce_cnt; p0 = per_cnt;
    idle(40);
    chk("R8 no cpu_ce in halt", ce_cnt - c0, 0);
    chk("R11 periph in halt", (per_cnt - p0 >= 19) ? 1 : 0, 1);
    pulse(wake_irq);
    idle(8);
    chk("R8 resumes after wake", (ce_cnt - c0 > 0) ? 1 : 0, 1);

    // R3 sub source
    wait_ces(1);
    wr(1'b1, 4'h1);
    wait_ces(3);
    chk("R3 sub period", last_per, 12);
    chk("R3 src flag", cpu_src_sub, 1);

    // R7 stop ignored on sub
    c0 = ce_cnt;
    pulse(stop_req);
    idle(40);
    chk("R7 cpu continues", (ce_cnt - c0 >= 3) ? 1 : 0, 1);
    chk("R7 osc unchanged", main_osc_on, 1);

    // R5 stop bit accepted on sub
    wr(1'b1, 4'h9);
    idle(2);
    chk("R5 osc stopped", main_osc_on, 0);
    p0 = per_cnt;
    wait_ces(2);
    chk("R5 sub keeps period", last_per, 12);
    idle(30);
    chk("R11 no periph osc off", per_cnt - p0, 0);

    // R8 halt on sub with main stopped
    pulse(halt_req);
    idle(2);
    c0 = ce_cnt;
    idle(40);
    chk("R8 halt on sub", ce_cnt - c0, 0);
    pulse(wake_irq);
    idle(20);
    chk("R8 wake on sub", (ce_cnt - c0 > 0) ? 1 : 0, 1);

    // back to main: R4 boundary switch, R2 period
    wait_ces(1);
    wr(1'b1, 4'h0);
    @(negedge clk);
    chk("R5 osc back on", main_osc_on, 1);
    wait_ces(3);
    chk("R2 main again", last_per, exp_main(cur_spd));
    chk("R3 src flag cleared", cpu_src_sub, 0);

    chk("R10 watch follows sub", watch_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule